// File: doc/BRIEF.md
# Interlocked clock control register

This block is the 8-bit control and status register of a clock generator with two sources, an internal one and an external one. Software reaches it through a select, a read strobe and a write strobe with 8-bit write and read data. The register drives the two generator enables, the clock-select line, the clock-monitor enable and an interrupt request. It takes in stable indications from both generators, loss reports from the inactivity detector, and the stop-mode and oscillator-enable-in-stop levels.

Almost every writable bit is guarded. A write may only move a bit when a qualifying combination of other bits has held for at least one full clock cycle. Hardware forcing rules always override software writes. A detected clock loss switches the clock select over to the surviving source without software action. The monitor flag is cleared only by a read that returned it as 1 followed by a write of 0.

Top module: `clk_ctrl_reg`

## Requirements
- R1: Register bit order, MSB first: irqEn(7), monFlag(6), monOn(5), clkSel(4), intOn(3), intStable(2), extOn(1), extStable(0). rdData shows the register while sel and rdEn are both high, and is 0 otherwise. After reset intOn is 1, the other stored bits are 0, and the read value is 0x08 when both stable inputs are low.
- R2: Bits 2 and 0 mirror intStableIn and extStableIn. Writes to bits 2 and 0 have no effect.
- R3: irqOut is 1 exactly when irqEn and monFlag are both 1.
- R4: A write of 1 to irqEn takes effect only if monOn has been 1 for at least one full cycle before the write edge. irqEn is forced to 0 whenever monOn is 0.
- R5: monFlag sets when monOn is 1 and either loss input is high. A loss input has no effect while monOn is 0. monFlag is forced to 0 whenever monOn is 0.
- R6: monFlag is cleared only by a write with bit 6 at 0 that follows a read returning monFlag as 1. Any write cancels a pending read. A write of 0 with no prior read leaves the flag set.
- R7: A write of 1 to monOn takes effect only if intOn, extOn, intStable and extStable have all been 1 for at least one full cycle before the write edge.
- R8: monOn is held at 1 while monFlag is 1. monOn is forced to 0 when intOn or extOn is 0, or when stopMode is high while oscInStop is low.
- R9: A write of 1 to clkSel takes effect only after extOn and extStable have held 1 for a full cycle. A write of 0 takes effect only after intOn and intStable have held 1 for a full cycle.
- R10: clkSel is forced to 1 on an effective internal loss or when intOn is 0. It is forced to 0 on an effective external loss or when extOn is 0. When both forces apply, 0 wins. A loss is effective only while monOn is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register select |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data |
| intStableIn | input | 1 | Internal clock stable |
| extStableIn | input | 1 | External clock stable |
| intLossIn | input | 1 | Detector reports internal clock stopped |
| extLossIn | input | 1 | Detector reports external clock stopped |
| stopMode | input | 1 | Device is in stop mode |
| oscInStop | input | 1 | Oscillator kept running in stop mode |
| intGenEn | output | 1 | Internal generator enable |
| extGenEn | output | 1 | External generator enable |
| clkSelOut | output | 1 | 1 selects the external source |
| monEnOut | output | 1 | Clock monitor enable |
| irqOut | output | 1 | Clock monitor interrupt request |

## Verification
The bench goes after the one-cycle hold windows by writing in the same cycle a qualifier becomes true. A design that gated on the live value instead of the held value would accept those early writes of clkSel, monOn and irqEn. The flag-clear sequence is tested with a write of 0 and no prior read, which a careless design would treat as a clear. A write of 0 to monOn while the flag is set would let a design without the hold drop the monitor. Simultaneous internal and external loss is driven to show the internal source wins. Stop mode with and without oscInStop is driven to catch a design that ignores the enable level.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
  localparam int REG_W = 8;
  localparam int B_IRQ  = 7;
  localparam int B_FLAG = 6;
  localparam int B_MON  = 5;
  localparam int B_SEL  = 4;
  localparam int B_ION  = 3;
  localparam int B_IST  = 2;
  localparam int B_EON  = 1;
  localparam int B_EST  = 0;

  // Write strobes and qualifiers passed from control to datapath
  typedef struct packed {
    logic wr;
    logic monOk;
    logic irqOk;
    logic selHiOk;
    logic selLoOk;
    logic clrOk;
  } strobe_t;

  // Stored register state
  typedef struct packed {
    logic irqEn;
    logic flag;
    logic monOn;
    logic clkSel;
    logic intOn;
    logic extOn;
  } state_t;
endpackage

// File: rtl/clk_ctrl_seq.sv
module clk_ctrl_seq
  import clk_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sel,
  input  logic    rdEn,
  input  logic    wrEn,
  input  state_t  st,
  input  logic    intStable,
  input  logic    extStable,
  output strobe_t stb
);
  logic qualBoth, qualExt, qualInt, monHeld, armed;
  logic wrHit, rdHit;

  assign wrHit = sel & wrEn;
  assign rdHit = sel & rdEn;

  // Qualifiers sampled one edge earlier so the state must already hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualBoth <= 1'b0;
      qualExt  <= 1'b0;
      qualInt  <= 1'b0;
      monHeld  <= 1'b0;
      armed    <= 1'b0;
    end else begin
      qualBoth <= st.intOn & st.extOn & intStable & extStable;
      qualExt  <= st.extOn & extStable;
      qualInt  <= st.intOn & intStable;
      monHeld  <= st.monOn;
      if (wrHit)
        armed <= 1'b0;
      else if (rdHit && st.flag)
        armed <= 1'b1;
    end
  end

  always_comb begin
    stb.wr      = wrHit;
    stb.monOk   = qualBoth;
    stb.irqOk   = monHeld & st.monOn;
    stb.selHiOk = qualExt;
    stb.selLoOk = qualInt;
    stb.clrOk   = armed;
  end
endmodule

// File: rtl/clk_ctrl_dp.sv
module clk_ctrl_dp
  import clk_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [REG_W-1:0] wrData,
  input  logic             stopMode,
  input  logic             oscInStop,
  input  logic             intLoss,
  input  logic             extLoss,
  output state_t           st
);
  state_t nx;
  logic   intLossEff, extLossEff, monForceOff, selForceLo, selForceHi;
  logic   unusedBits;

  assign unusedBits = wrData[B_IST] ^ wrData[B_EST];

  always_comb begin
    nx = st;
    intLossEff = st.monOn & intLoss;
    extLossEff = st.monOn & extLoss;

    // Generator enables: plain read/write
    if (stb.wr) begin
      nx.intOn = wrData[B_ION];
      nx.extOn = wrData[B_EON];
    end

    // Monitor enable: qualified set, held by flag, forced off
    monForceOff = !nx.intOn || !nx.extOn || (stopMode && !oscInStop);
    if (stb.wr)
      nx.monOn = wrData[B_MON] ? (st.monOn | stb.monOk) : 1'b0;
    if (st.flag)
      nx.monOn = 1'b1;
    if (monForceOff)
      nx.monOn = 1'b0;

    // Flag: set on effective loss, clear by armed write of 0
    if (stb.wr && stb.clrOk && !wrData[B_FLAG])
      nx.flag = 1'b0;
    if (intLossEff || extLossEff)
      nx.flag = 1'b1;
    if (!nx.monOn)
      nx.flag = 1'b0;

    // Interrupt enable
    if (stb.wr)
      nx.irqEn = wrData[B_IRQ] ? (st.irqEn | stb.irqOk) : 1'b0;
    if (!nx.monOn)
      nx.irqEn = 1'b0;

    // Clock select: qualified writes, fail-safe forcing, low wins
    if (stb.wr)
      nx.clkSel = wrData[B_SEL] ? (st.clkSel | stb.selHiOk)
                                : (st.clkSel & !stb.selLoOk);
    selForceHi = intLossEff || !nx.intOn;
    selForceLo = extLossEff || !nx.extOn;
    if (selForceHi)
      nx.clkSel = 1'b1;
    if (selForceLo)
      nx.clkSel = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= '{irqEn: 1'b0, flag: 1'b0, monOn: 1'b0, clkSel: 1'b0,
              intOn: 1'b1, extOn: 1'b0};
    end else begin
      st <= nx;
    end
  end
endmodule

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg
  import clk_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             intStableIn,
  input  logic             extStableIn,
  input  logic             intLossIn,
  input  logic             extLossIn,
  input  logic             stopMode,
  input  logic             oscInStop,
  output logic             intGenEn,
  output logic             extGenEn,
  output logic             clkSelOut,
  output logic             monEnOut,
  output logic             irqOut
);
  state_t  st;
  strobe_t stb;
  logic [REG_W-1:0] regView;

  clk_ctrl_seq u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .sel       (sel),
    .rdEn      (rdEn),
    .wrEn      (wrEn),
    .st        (st),
    .intStable (intStableIn),
    .extStable (extStableIn),
    .stb       (stb)
  );

  clk_ctrl_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .stopMode  (stopMode),
    .oscInStop (oscInStop),
    .intLoss   (intLossIn),
    .extLoss   (extLossIn),
    .st        (st)
  );

  always_comb begin
    regView         = '0;
    regView[B_IRQ]  = st.irqEn;
    regView[B_FLAG] = st.flag;
    regView[B_MON]  = st.monOn;
    regView[B_SEL]  = st.clkSel;
    regView[B_ION]  = st.intOn;
    regView[B_IST]  = intStableIn;
    regView[B_EON]  = st.extOn;
    regView[B_EST]  = extStableIn;
  end

  assign rdData    = (sel && rdEn) ? regView : '0;
  assign intGenEn  = st.intOn;
  assign extGenEn  = st.extOn;
  assign clkSelOut = st.clkSel;
  assign monEnOut  = st.monOn;
  assign irqOut    = st.irqEn & st.flag;
endmodule

// File: rtl/clk_ctrl_reg_sva.sv
module clk_ctrl_reg_sva (
  input logic clk,
  input logic rstN,
  input logic extLossIn,
  input logic stopMode,
  input logic oscInStop,
  input logic intGenEn,
  input logic extGenEn,
  input logic clkSelOut,
  input logic monEnOut,
  input logic irqOut
);
  // R8: monitor only runs with both generators on
  p_mon_needs_gens_r8: assert property (@(posedge clk) disable iff (!rstN)
    monEnOut |-> (intGenEn && extGenEn));

  // R8: stop without oscillator drops the monitor
  p_mon_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && !oscInStop) |=> !monEnOut);

  // R10: external generator off never selects external source
  p_ext_off_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    !extGenEn |-> !clkSelOut);

  // R10: effective external loss falls back to internal
  p_ext_loss_fallback_r10: assert property (@(posedge clk) disable iff (!rstN)
    (monEnOut && extLossIn) |=> !clkSelOut);

  // R4: interrupt only possible while monitor is on
  p_irq_needs_mon_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> monEnOut);
endmodule

bind clk_ctrl_reg clk_ctrl_reg_sva u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .extLossIn (extLossIn),
  .stopMode  (stopMode),
  .oscInStop (oscInStop),
  .intGenEn  (intGenEn),
  .extGenEn  (extGenEn),
  .clkSelOut (clkSelOut),
  .monEnOut  (monEnOut),
  .irqOut    (irqOut)
);

// File: tb/clk_ctrl_reg_tb.sv
`timescale 1ns/1ps
module clk_ctrl_reg_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sel = 0, rdEn = 0, wrEn = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic intStableIn = 0, extStableIn = 0, intLossIn = 0, extLossIn = 0;
  logic stopMode = 0, oscInStop = 0;
  logic intGenEn, extGenEn, clkSelOut, monEnOut, irqOut;
  int nRun = 0, nFail = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  clk_ctrl_reg u_dut (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); sel = 1; wrEn = 1; wrData = d;
    @(posedge clk); #1 sel = 0; wrEn = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); sel = 1; rdEn = 1; #1 d = rdData;
    @(posedge clk); #1 sel = 0; rdEn = 0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input logic iL, input logic eL);
    @(negedge clk); intLossIn = iL; extLossIn = eL;
    @(posedge clk); #1 intLossIn = 0; extLossIn = 0;
  endtask

  task automatic t_reset();
    chk("R1 idle rdData", rdData, 8'h00);
    rd(v); chk("R1 reset value", v, 8'h08);
    chk("R1 outputs", {3'b0, intGenEn, extGenEn, clkSelOut, monEnOut, irqOut}, 8'h10);
  endtask

  task automatic t_readonly();
    wr(8'h0D); rd(v); chk("R2 status bits ignore write", v, 8'h08);
    intStableIn = 1; extStableIn = 1;
    rd(v); chk("R2 status bits mirror inputs", v, 8'h0D);
  endtask

  task automatic t_select_gate();
    wr(8'h1A); chk("R9 select blocked before ext held", clkSelOut, 0);
    idle(); wr(8'h1A); chk("R9 select to external", clkSelOut, 1);
    intStableIn = 0; idle(); wr(8'h0A);
    chk("R9 return blocked without int stable", clkSelOut, 1);
    rd(v); chk("R9 readback", v, 8'h1B);
    intStableIn = 1; idle(); wr(8'h0A);
    chk("R9 return to internal", clkSelOut, 0);
  endtask

  task automatic t_mon_gate();
    extStableIn = 0; idle(); wr(8'h2A);
    chk("R7 monitor blocked without ext stable", monEnOut, 0);
    extStableIn = 1; idle(); wr(8'h2A);
    chk("R7 monitor on", monEnOut, 1);
  endtask

  task automatic t_irq_gate();
    wr(8'hAA); rd(v); chk("R4 irqEn blocked right after monOn", v, 8'h2F);
    wr(8'hAA); rd(v); chk("R4 irqEn set", v, 8'hAF);
    chk("R3 no irq without flag", irqOut, 0);
  endtask

  task automatic t_flag_set();
    pulse(0, 1);
    chk("R3 irq with enable and flag", irqOut, 1);
    chk("R10 ext loss keeps internal", clkSelOut, 0);
  endtask

  task automatic t_flag_clear();
    wr(8'h8F);
    chk("R6 unarmed clear ignored", irqOut, 1);
    chk("R8 monOn held by flag", monEnOut, 1);
    rd(v); chk("R5 flag reads set", v, 8'hEF);
    wr(8'hAF);
    chk("R6 armed clear", irqOut, 0);
    rd(v); chk("R6 flag cleared", v, 8'hAF);
  endtask

  task automatic t_stop();
    stopMode = 1; oscInStop = 1; idle();
    chk("R8 stop with osc keeps monitor", monEnOut, 1);
    oscInStop = 0; idle();
    chk("R8 stop without osc drops monitor", monEnOut, 0);
    rd(v); chk("R4 irqEn forced off", v, 8'h0F);
    stopMode = 0; pulse(0, 1);
    rd(v); chk("R5 loss ignored with monitor off", v, 8'h0F);
  endtask

  task automatic t_force();
    wr(8'h2A); chk("R7 monitor back on", monEnOut, 1);
    wr(8'h22); rd(v); chk("R8 R10 internal off forces", v, 8'h17);
    wr(8'h1A); idle(); wr(8'h3A);
    chk("R10 select external", clkSelOut, 1);
    wr(8'h2A); chk("R9 select internal", clkSelOut, 0);
    pulse(1, 0); chk("R10 int loss forces external", clkSelOut, 1);
    pulse(0, 1); chk("R10 ext loss forces internal", clkSelOut, 0);
    wr(8'h3A); chk("R10 select external again", clkSelOut, 1);
    pulse(1, 1); chk("R10 both losses favour internal", clkSelOut, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_readonly();
    t_select_gate();
    t_mon_gate();
    t_irq_gate();
    t_flag_set();
    t_flag_clear();
    t_stop();
    t_force();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule